// File: doc/BRIEF.md
# I2C Read-Side Slave with Clock Stretching

This block is the target side of an I2C bus for transfers in which the master reads. It watches the bus for START and repeated START conditions. It takes in the 7-bit address frame and acknowledges it only when the address equals its own, the direction bit requests a read, and no transfer is already under way. It then sends bytes that a local processor places in a data-out register, most significant bit first. After each acknowledged address or data byte it holds SCL low until the processor has cleared the interrupt flag, so the processor can load the next byte at its own pace. Software sees a small set of sticky status flags and an interrupt line, and clears each flag with a one-cycle write-one-to-clear strobe.

The open-drain lines are modelled as two drive-low enables (`scl_oe`, `sda_oe`) and two sampled line inputs. Both inputs pass through a synchronizer before edge and condition detection. A master NACK ends the transfer. The slave goes back to idle and releases SDA, and it ignores any bytes the master clocks afterwards. A repeated START after that NACK only marks the START flag. A STOP raises the interrupt without stretching.

States of the engine: IDLE (bus ignored), ADDR (shifting in the address frame), AACK (driving the address ACK), HOLD (SCL held low, waiting for the interrupt flag to clear), SEND (shifting a data byte out), MACK (released SDA, sampling the master's ACK or NACK). Transitions: any state to ADDR on START; any state to IDLE on STOP; ADDR to AACK on a match at the 8th SCL falling edge, otherwise ADDR to IDLE; AACK to HOLD at the 9th falling edge; HOLD to SEND once the interrupt flag reads clear; SEND to MACK at the 8th falling edge; MACK to HOLD at the 9th falling edge after an ACK; MACK to IDLE at the 9th falling edge after a NACK.

Top module: `i2c_rd_slave`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `irq` and every status output are 0.
- R2: A START, then an address frame equal to `OWN_ADDR` with direction bit 1 (bit 0 of the frame, sent last), while `stat_busy` is 0, is acknowledged: SDA is low during the 9th SCL high phase. At the 9th SCL falling edge `irq`, `stat_start`, `stat_read` and `stat_busy` become 1.
- R3: An address frame with any other address, or with direction bit 0, gets no ACK. It raises no interrupt, and SDA stays released for the bytes that follow and for the STOP.
- R4: After an acknowledged address or data byte, `scl_oe` is 1 from the 9th SCL falling edge until `irq` is cleared. It drops within two clock cycles of the clear.
- R5: Each data byte is the value in the data-out register when the interrupt was cleared. It goes out most significant bit first, and every bit changes only while SCL is low.
- R6: A master ACK (SDA low on the 9th SCL rising edge of a data byte) sets `irq` at the 9th falling edge and stretches SCL again.
- R7: A master NACK on a data byte sets `stat_nack` and `irq`, clears `stat_busy` and returns to idle. Bytes clocked afterwards read as all ones and raise no interrupt.
- R8: A repeated START after a NACK sets `stat_start` without raising `irq`. A matching read address that follows is acknowledged again, as in R2.
- R9: A STOP after an acknowledged address sets `stat_stop` and `irq`, clears `stat_busy` and `stat_read`, and never drives `scl_oe`.
- R10: Each clear strobe (`clr_int`, `clr_start`, `clr_stop`, `clr_nack`) clears only its own flag on the next clock edge.
- R11: A matching read address that arrives while `stat_busy` is 1 (repeated START without a prior NACK) is not acknowledged and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| dout_wr | input | 1 | Write strobe for the data-out register |
| dout_data | input | ADDR_W+1 | Byte written into data-out |
| clr_int | input | 1 | Write-one-to-clear for the interrupt flag |
| clr_start | input | 1 | Write-one-to-clear for the START flag |
| clr_stop | input | 1 | Write-one-to-clear for the STOP flag |
| clr_nack | input | 1 | Write-one-to-clear for the NACK flag |
| irq | output | 1 | Interrupt flag |
| stat_start | output | 1 | START or repeated START seen |
| stat_stop | output | 1 | STOP seen during an addressed transfer |
| stat_nack | output | 1 | Master NACKed a data byte |
| stat_read | output | 1 | Addressed for a read, until STOP |
| stat_busy | output | 1 | Read transfer in progress (from address ACK to NACK or STOP) |

## Verification
A wrong state in the engine shows on the bus within the same SCL bit. A missed bit count misplaces the ACK slot, so the master samples a 1 where it expects the address ACK, or a data byte comes back rotated. A wrong decision in HOLD shows as `scl_oe` stuck high after the clear, or never asserted after the 9th falling edge. Flag errors appear at the next 9th falling edge, or at the STOP, as a wrong `irq` or status bit. The bench sweeps every 7-bit address with the read bit and a range of data patterns, so each of these faults shows within one byte time.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_HOLD,
        ST_SEND,
        ST_MACK
    } eng_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // bit 1 = SCL, bit 0 = SDA; idle bus level is high
    logic [STAGES-1:0][1:0] pipe_q;
    logic [1:0]             prev_q;
    logic [1:0]             cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q[0] <= 2'b11;
        end else begin
            pipe_q[0] <= {scl_in, sda_in};
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q[g] <= 2'b11;
            end else begin
                pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign cur = pipe_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 2'b11;
        end else begin
            prev_q <= cur;
        end
    end

    assign sda_lvl   = cur[0];
    assign scl_rise  = cur[1] & ~prev_q[1];
    assign scl_fall  = ~cur[1] & prev_q[1];
    assign start_det = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
    assign stop_det  = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];

endmodule

// File: rtl/i2c_rd_flags.sv
module i2c_rd_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_start,
    input  logic set_stop,
    input  logic set_nack,
    input  logic set_read,
    input  logic set_int,
    input  logic clr_int,
    input  logic clr_start,
    input  logic clr_stop,
    input  logic clr_nack,
    output logic f_start,
    output logic f_stop,
    output logic f_nack,
    output logic f_read,
    output logic f_int
);

    // a set from the engine wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_start <= 1'b0;
            f_stop  <= 1'b0;
            f_nack  <= 1'b0;
            f_read  <= 1'b0;
            f_int   <= 1'b0;
        end else begin
            f_start <= set_start | (f_start & ~clr_start);
            f_stop  <= set_stop  | (f_stop  & ~clr_stop);
            f_nack  <= set_nack  | (f_nack  & ~clr_nack);
            f_int   <= set_int   | (f_int   & ~clr_int);
            f_read  <= set_read  | (f_read  & ~set_stop);
        end
    end

endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
    import i2c_rd_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h3A,
    localparam int               BYTE_W   = ADDR_W + 1,
    localparam int               CNT_W    = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              irq_pend,
    input  logic [BYTE_W-1:0] dout,
    output logic              busy,
    output logic              scl_hold,
    output logic              sda_low,
    output logic              set_start,
    output logic              set_stop,
    output logic              set_nack,
    output logic              set_read,
    output logic              set_int
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    eng_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [BYTE_W-1:0] sh_q, sh_n;
    logic              mack_q, mack_n;
    logic              busy_q, busy_n;
    logic              eng_q, eng_n;

    // next state and event pulses
    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        sh_n      = sh_q;
        mack_n    = mack_q;
        busy_n    = busy_q;
        eng_n     = eng_q;
        set_start = 1'b0;
        set_stop  = 1'b0;
        set_nack  = 1'b0;
        set_read  = 1'b0;
        set_int   = 1'b0;
        if (stop_det) begin
            state_n = ST_IDLE;
            busy_n  = 1'b0;
            eng_n   = 1'b0;
            if (eng_q) begin
                set_stop = 1'b1;
                set_int  = 1'b1;
            end
        end else if (start_det) begin
            state_n   = ST_ADDR;
            cnt_n     = '0;
            set_start = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise && cnt_q < CNT_FULL) begin
                        sh_n  = {sh_q[BYTE_W-2:0], sda_lvl};
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == CNT_FULL) begin
                        if (sh_q[BYTE_W-1:1] == OWN_ADDR && sh_q[0] && !busy_q) begin
                            state_n = ST_AACK;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        state_n  = ST_HOLD;
                        set_int  = 1'b1;
                        set_read = 1'b1;
                        busy_n   = 1'b1;
                        eng_n    = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!irq_pend) begin
                        state_n = ST_SEND;
                        sh_n    = dout;
                        cnt_n   = '0;
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        sh_n = {sh_q[BYTE_W-2:0], 1'b1};
                        if (cnt_q == CNT_LAST) begin
                            state_n = ST_MACK;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack_n = sda_lvl;
                    end else if (scl_fall) begin
                        set_int = 1'b1;
                        if (!mack_q) begin
                            state_n = ST_HOLD;
                        end else begin
                            state_n  = ST_IDLE;
                            set_nack = 1'b1;
                            busy_n   = 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            mack_q  <= 1'b1;
            busy_q  <= 1'b0;
            eng_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            mack_q  <= mack_n;
            busy_q  <= busy_n;
            eng_q   <= eng_n;
        end
    end

    // line drivers
    always_comb begin
        scl_hold = 1'b0;
        sda_low  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: ;
            ST_AACK: sda_low = 1'b1;
            ST_HOLD: begin
                scl_hold = 1'b1;
                sda_low  = ~dout[BYTE_W-1];
            end
            ST_SEND: sda_low = ~sh_q[BYTE_W-1];
            ST_MACK: ;
        endcase
    end

    assign busy = busy_q;

endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave #(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h3A,
    parameter int                SYNC_STAGES = 2,
    localparam int               BYTE_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              dout_wr,
    input  logic [BYTE_W-1:0] dout_data,
    input  logic              clr_int,
    input  logic              clr_start,
    input  logic              clr_stop,
    input  logic              clr_nack,
    output logic              irq,
    output logic              stat_start,
    output logic              stat_stop,
    output logic              stat_nack,
    output logic              stat_read,
    output logic              stat_busy
);

    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              set_start, set_stop, set_nack, set_read, set_int;
    logic [BYTE_W-1:0] dout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '1;
        end else if (dout_wr) begin
            dout_q <= dout_data;
        end
    end

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rd_engine #(.ADDR_W(ADDR_W), .OWN_ADDR(OWN_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .irq_pend  (irq),
        .dout      (dout_q),
        .busy      (stat_busy),
        .scl_hold  (scl_oe),
        .sda_low   (sda_oe),
        .set_start (set_start),
        .set_stop  (set_stop),
        .set_nack  (set_nack),
        .set_read  (set_read),
        .set_int   (set_int)
    );

    i2c_rd_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_start (set_start),
        .set_stop  (set_stop),
        .set_nack  (set_nack),
        .set_read  (set_read),
        .set_int   (set_int),
        .clr_int   (clr_int),
        .clr_start (clr_start),
        .clr_stop  (clr_stop),
        .clr_nack  (clr_nack),
        .f_start   (stat_start),
        .f_stop    (stat_stop),
        .f_nack    (stat_nack),
        .f_read    (stat_read),
        .f_int     (irq)
    );

endmodule

// File: rtl/i2c_rd_slave_chk.sv
module i2c_rd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic irq,
    input logic stat_stop,
    input logic stat_nack,
    input logic stat_read,
    input logic stat_busy
);

    // R4
    hold_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> irq);

    // R4
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |=> !scl_oe);

    // R9
    stop_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_stop) |-> (!scl_oe && irq && !stat_busy));

    // R7
    nack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_nack) |-> (!stat_busy && !sda_oe && !scl_oe && irq));

    // R2
    busy_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_busy) |-> (stat_read && irq));

endmodule

bind i2c_rd_slave i2c_rd_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq       (irq),
    .stat_stop (stat_stop),
    .stat_nack (stat_nack),
    .stat_read (stat_read),
    .stat_busy (stat_busy)
);

// File: tb/i2c_rd_slave_tb.sv
module i2c_rd_slave_tb;

    localparam logic [6:0] OWN = 7'h3A;
    localparam int         HP  = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic scl_m, sda_m;
    logic scl_oe, sda_oe;
    logic dout_wr;
    logic [7:0] dout_data;
    logic clr_int, clr_start, clr_stop, clr_nack;
    logic irq, stat_start, stat_stop, stat_nack, stat_read, stat_busy;
    wire  scl_line = scl_m & ~scl_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    i2c_rd_slave #(.ADDR_W(7), .OWN_ADDR(OWN), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .dout_wr(dout_wr), .dout_data(dout_data),
        .clr_int(clr_int), .clr_start(clr_start), .clr_stop(clr_stop), .clr_nack(clr_nack),
        .irq(irq), .stat_start(stat_start), .stat_stop(stat_stop), .stat_nack(stat_nack),
        .stat_read(stat_read), .stat_busy(stat_busy)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b;
        wait_n(HP);
        scl_m = 1'b1;
        wait_n(1);
        while (!scl_line) wait_n(1);
        wait_n(HP);
        r = sda_line;
        wait_n(HP);
        scl_m = 1'b0;
        wait_n(HP);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_n(2*HP);
        sda_m = 1'b0; wait_n(2*HP);
        scl_m = 1'b0; wait_n(HP);
    endtask

    task automatic m_rstart();
        sda_m = 1'b1; wait_n(HP);
        scl_m = 1'b1; wait_n(1);
        while (!scl_line) wait_n(1);
        wait_n(2*HP);
        sda_m = 1'b0; wait_n(2*HP);
        scl_m = 1'b0; wait_n(HP);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wait_n(HP);
        scl_m = 1'b1; wait_n(1);
        while (!scl_line) wait_n(1);
        wait_n(2*HP);
        sda_m = 1'b1; wait_n(2*HP);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        m_bit(1'b1, ack);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            v[i] = r;
        end
        m_bit(nack, r);
    endtask

    task automatic cpu_write(input logic [7:0] d);
        dout_data = d; dout_wr = 1'b1;
        wait_n(1);
        dout_wr = 1'b0;
    endtask

    task automatic cpu_clr(input logic ci, input logic cs, input logic cp, input logic cn);
        clr_int = ci; clr_start = cs; clr_stop = cp; clr_nack = cn;
        wait_n(1);
        clr_int = 1'b0; clr_start = 1'b0; clr_stop = 1'b0; clr_nack = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        logic [7:0] p;
        p = 8'h80 >> i;
        if (i % 2 == 1) p = ~p;
        return p;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic       ak;
        logic [7:0] v;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        dout_wr = 1'b0; dout_data = 8'h00;
        clr_int = 1'b0; clr_start = 1'b0; clr_stop = 1'b0; clr_nack = 1'b0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);

        // R1 reset state
        check("R1 lines", {scl_oe, sda_oe}, 2'b00);
        check("R1 flags", {irq, stat_start, stat_stop, stat_nack, stat_read, stat_busy}, 6'b0);

        // address sweep, read bit set: only OWN is ACKed (R2, R3)
        for (int a = 0; a < 128; a++) begin
            m_start();
            send_byte({a[6:0], 1'b1}, ak);
            if (a[6:0] == OWN) begin
                check("R2 addr ack", ak, 1'b0);
                wait_n(2);
                check("R2 flags", {irq, stat_start, stat_read, stat_busy}, 4'b1111);
                cpu_write(8'hC3);
                cpu_clr(1'b1, 1'b1, 1'b0, 1'b0);
                read_byte(1'b1, v);
                check("R5 sweep byte", v, 8'hC3);
                m_stop();
                check("R9 sweep stop", {stat_stop, irq}, 2'b11);
                cpu_clr(1'b1, 1'b1, 1'b1, 1'b1);
            end else begin
                check("R3 no ack", ak, 1'b1);
                check("R3 no irq", irq, 1'b0);
                if (a[3:0] == 4'd0) begin
                    read_byte(1'b1, v);
                    check("R3 sda released", v, 8'hFF);
                end
                m_stop();
                check("R3 no irq after stop", {irq, stat_stop}, 2'b00);
            end
        end

        // R3 write direction to own address
        m_start();
        send_byte({OWN, 1'b0}, ak);
        check("R3 write bit no ack", ak, 1'b1);
        check("R3 write bit no irq", irq, 1'b0);
        m_stop();
        cpu_clr(1'b0, 1'b1, 1'b0, 1'b0);

        // main read transfer with a pattern sweep
        m_start();
        send_byte({OWN, 1'b1}, ak);
        check("R2 main ack", ak, 1'b0);
        wait_n(4);
        check("R4 stretch after addr", {scl_oe, irq}, 2'b11);
        cpu_clr(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 clr start only", {stat_start, irq}, 2'b01);
        wait_n(20);
        check("R4 held while irq", scl_oe, 1'b1);
        cpu_write(pat(0));
        cpu_clr(1'b1, 1'b0, 1'b0, 1'b0);
        wait_n(2);
        check("R4 release", scl_oe, 1'b0);
        for (int i = 0; i < 8; i++) begin
            read_byte(i == 7, v);
            check("R5 data msb first", v, pat(i));
            wait_n(2);
            if (i < 7) begin
                check("R6 ack stretch", {irq, scl_oe, stat_nack}, 3'b110);
                cpu_write(pat(i + 1));
                cpu_clr(1'b1, 1'b0, 1'b0, 1'b0);
                wait_n(2);
                check("R4 release data", scl_oe, 1'b0);
            end else begin
                check("R7 nack flags", {stat_nack, irq, stat_busy, scl_oe, sda_oe}, 5'b11000);
            end
        end
        cpu_clr(1'b1, 1'b0, 1'b0, 1'b1);
        read_byte(1'b1, v);
        check("R7 ignored byte", v, 8'hFF);
        check("R7 no irq", irq, 1'b0);

        // R8 repeated START after NACK
        m_rstart();
        check("R8 start no irq", {stat_start, irq}, 2'b10);
        send_byte({OWN, 1'b1}, ak);
        check("R8 re-addressed ack", ak, 1'b0);
        wait_n(2);
        check("R8 irq busy", {irq, stat_busy}, 2'b11);
        cpu_clr(1'b0, 1'b1, 1'b0, 1'b0);
        cpu_write(8'h3C);
        cpu_clr(1'b1, 1'b0, 1'b0, 1'b0);
        read_byte(1'b1, v);
        check("R5 after rstart", v, 8'h3C);
        cpu_clr(1'b1, 1'b0, 1'b0, 1'b1);

        // R9 STOP
        m_stop();
        check("R9 stop flags", {stat_stop, irq, scl_oe, stat_busy, stat_read}, 5'b11000);
        cpu_clr(1'b0, 1'b0, 1'b1, 1'b0);
        check("R10 clr stop only", {stat_stop, irq}, 2'b01);
        cpu_clr(1'b1, 1'b0, 1'b0, 1'b0);
        check("R10 clr int", {irq, stat_start, stat_stop, stat_nack}, 4'b0000);

        // R11 repeated START while busy
        m_start();
        send_byte({OWN, 1'b1}, ak);
        check("R2 ack before busy test", ak, 1'b0);
        cpu_write(8'hFF);
        cpu_clr(1'b1, 1'b1, 1'b0, 1'b0);
        read_byte(1'b0, v);
        check("R5 all ones", v, 8'hFF);
        wait_n(2);
        check("R6 stretch", {irq, scl_oe}, 2'b11);
        cpu_write(8'hFF);
        cpu_clr(1'b1, 1'b0, 1'b0, 1'b0);
        m_rstart();
        check("R11 still busy", {stat_start, stat_busy, irq}, 3'b110);
        send_byte({OWN, 1'b1}, ak);
        check("R11 busy no ack", ak, 1'b1);
        check("R11 busy no irq", irq, 1'b0);
        m_stop();
        check("R9 stop after busy", {stat_stop, irq, stat_busy}, 3'b110);
        cpu_clr(1'b1, 1'b1, 1'b1, 1'b1);
        check("R10 all cleared", {irq, stat_start, stat_stop, stat_nack, stat_read, stat_busy}, 6'b0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule